// File: doc/BRIEF.md
# Split Dual 8-bit Auto-Reload Timer

This block holds two independent 8-bit up-counters, a low half and a high half. Each half has its own reload value. When a half counts past its top value it does not roll to zero: it takes its reload value and sets its own overflow flag. The flag stays set until software writes it. All logic runs on one system clock. Counting is gated by one-cycle enables, so no derived clock exists.

Each half picks its count rate from three sources: every system clock cycle, one cycle in twelve, or one pulse per eighth rising edge of an external clock. The external clock is synchronized into the system clock domain before its edges are counted, so it must run no faster than the system clock. The high half counts only while a run bit is set. The low half always counts. An interrupt request level combines the two flags under a global enable. The low flag joins the request only when a second enable bit is set. A one-cycle strobe marks each low-half wrap so that other peripherals can use it.

Top module: `dual_reload_timer`

## Requirements
- R1: After a synchronous reset, both counters, both reload values, the control fields, both flags, `irq` and `lo_wrap_stb` are all zero.
- R2: A write (`wr_en`=1) goes to the register selected by `wr_addr`. Address 0 is control, taking `wr_data[5:0]`: bit0 high-half run, bit1 external select, bit2 high-half system-clock mode, bit3 low-half system-clock mode, bit4 interrupt enable, bit5 low-flag interrupt enable. Address 1 is the flags: bit0 low flag, bit1 high flag. Address 2 is the low reload value, address 3 the high reload value, address 4 the low counter and address 5 the high counter. The new value is visible one cycle after the write.
- R3: The high counter advances only on a count enable that arrives while the run bit is 1. The low counter advances on every count enable, whatever the run bit holds.
- R4: A count enable that arrives while a counter holds 0xFF loads that half's reload value into the counter, in place of 0x00.
- R5: A half whose mode bit is 1 counts on every cycle. When its mode bit is 0, it counts on one cycle in twelve if external select is 0. If external select is 1, it counts once per eighth rising edge of `ext_clk`, seen after a two-flop synchronizer.
- R6: A wrap sets that half's flag, and the flag stays set until a flag write. A flag write in the same cycle as a wrap takes precedence over the set.
- R7: `irq` equals interrupt enable AND (high flag OR (low flag AND low-flag enable)), taken from the register values one cycle earlier.
- R8: `lo_wrap_stb` is high for exactly the one cycle after each low-half wrap edge, which is the same cycle the low flag is first visible.
- R9: A counter write takes precedence over a count enable in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | Asynchronous external count clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | W | Write data |
| cnt_lo | output | W | Low-half counter value |
| cnt_hi | output | W | High-half counter value |
| flag_lo | output | 1 | Low-half sticky overflow flag |
| flag_hi | output | 1 | High-half sticky overflow flag |
| irq | output | 1 | Interrupt request level |
| lo_wrap_stb | output | 1 | One-cycle low-half wrap strobe |

## Verification
Some rules are checked by assertions on every cycle. These are: the reload on wrap, counter-write precedence, the high counter holding while stopped, flag stickiness, `irq` staying low while disabled, and the fact that neither prescaler enable fires two cycles in a row. Other behaviour can only be shown by the bench's scenarios, which compare against a cycle-level model. That covers the exact one-in-twelve and eighth-edge rates with their synchronizer latency, a flag write winning over a simultaneous wrap, the strobe timing and each enable combination of `irq`.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_FLAG   = 3'd1;
  localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd5;

  localparam int CTRL_W = 6;

  // Control register layout, MSB first (bit5 .. bit0).
  typedef struct packed {
    logic lo_irq_en;
    logic irq_en;
    logic lo_sys;
    logic hi_sys;
    logic ext_sel;
    logic run_hi;
  } ctrl_t;

  localparam int LO = 0;
  localparam int HI = 1;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRE_DIV     = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_clk,
  output logic div_tick,
  output logic ext_tick
);
  localparam int DIV_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int EXT_W = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1;

  logic [DIV_W-1:0]       div_q;
  logic [EXT_W-1:0]       edge_q;
  logic [SYNC_STAGES:0]   sync_q;
  logic                   rise;

  // Free-running divider for the slow system-clock rate.
  always_ff @(posedge clk) begin
    if (rst)           div_q <= '0;
    else if (div_tick) div_q <= '0;
    else               div_q <= div_q + 1'b1;
  end
  assign div_tick = (div_q == DIV_W'(PRE_DIV - 1));

  // Synchronizer chain plus one history stage for edge detection.
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk};
  end
  assign rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst)           edge_q <= '0;
    else if (ext_tick) edge_q <= '0;
    else if (rise)     edge_q <= edge_q + 1'b1;
  end
  assign ext_tick = rise && (edge_q == EXT_W'(EXT_DIV - 1));

  // R5
  div_gap_chk: assert property (@(posedge clk) disable iff (rst)
    div_tick |=> !div_tick);

  // R5
  ext_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ext_tick |=> !ext_tick);
endmodule

// File: rtl/tmr_half.sv
module tmr_half #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = '1;

  assign wrap = tick && !load && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (wrap) cnt <= reload;
    else if (tick) cnt <= cnt + 1'b1;
  end

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && cnt == TOP) |=> (cnt == $past(reload)));

  // R9
  load_win_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import tmr_pkg::*;
#(
  parameter int W           = 8,
  parameter int PRE_DIV     = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      cnt_lo,
  output logic [W-1:0]      cnt_hi,
  output logic              flag_lo,
  output logic              flag_hi,
  output logic              irq,
  output logic              lo_wrap_stb
);
  ctrl_t             ctrl_q;
  logic [1:0]        flag_q;
  logic              irq_q;
  logic              stb_q;
  logic              div_tick;
  logic              ext_tick;
  logic              slow_tick;
  logic [1:0]        tick;
  logic [1:0]        load;
  logic [1:0]        wrap;
  logic [1:0][W-1:0] cnt_w;
  logic              wr_ctrl;
  logic              wr_flag;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_flag = wr_en && (wr_addr == A_FLAG);

  tmr_prescale #(
    .PRE_DIV     (PRE_DIV),
    .EXT_DIV     (EXT_DIV),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_pre (
    .clk      (clk),
    .rst      (rst),
    .ext_clk  (ext_clk),
    .div_tick (div_tick),
    .ext_tick (ext_tick)
  );

  assign slow_tick = ctrl_q.ext_sel ? ext_tick : div_tick;

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  for (genvar g = 0; g < 2; g++) begin : g_half
    localparam logic [ADDR_W-1:0] RLD_A = (g == HI) ? A_RLD_HI : A_RLD_LO;
    localparam logic [ADDR_W-1:0] CNT_A = (g == HI) ? A_CNT_HI : A_CNT_LO;

    logic [W-1:0] rld_q;
    logic         sys_mode;
    logic         gate;

    assign sys_mode = (g == HI) ? ctrl_q.hi_sys : ctrl_q.lo_sys;
    assign gate     = (g == HI) ? ctrl_q.run_hi : 1'b1;
    assign tick[g]  = gate & (sys_mode | slow_tick);
    assign load[g]  = wr_en && (wr_addr == CNT_A);

    always_ff @(posedge clk) begin
      if (rst)                              rld_q <= '0;
      else if (wr_en && wr_addr == RLD_A)   rld_q <= wr_data;
    end

    tmr_half #(.W(W)) u_half (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick[g]),
      .load     (load[g]),
      .load_val (wr_data),
      .reload   (rld_q),
      .cnt      (cnt_w[g]),
      .wrap     (wrap[g])
    );

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (flag_q[g] && !wr_flag) |=> flag_q[g]);
  end

  // Flag write takes precedence over a wrap in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)          flag_q <= '0;
    else if (wr_flag) flag_q <= wr_data[1:0];
    else              flag_q <= flag_q | wrap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      irq_q <= ctrl_q.irq_en & (flag_q[HI] | (flag_q[LO] & ctrl_q.lo_irq_en));
      stb_q <= wrap[LO];
    end
  end

  assign cnt_lo      = cnt_w[LO];
  assign cnt_hi      = cnt_w[HI];
  assign flag_lo     = flag_q[LO];
  assign flag_hi     = flag_q[HI];
  assign irq         = irq_q;
  assign lo_wrap_stb = stb_q;

  // R3
  hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.run_hi && !load[HI]) |=> $stable(cnt_hi));

  // R7
  irq_off_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q.irq_en |=> !irq);

  // R8
  stb_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap[LO] && !wr_flag) |=> (lo_wrap_stb && flag_lo));
endmodule

// File: tb/dual_reload_timer_tb_top.sv
module dual_reload_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ext_clk = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] cnt_lo, cnt_hi;
  logic         flag_lo, flag_hi, irq, lo_wrap_stb;

  int    total = 0;
  int    bad = 0;
  int    cyc = 0;
  bit    chk_on = 1'b0;
  bit    ext_run = 1'b0;
  int    ext_half = 2;
  int    ext_ph = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_reload_timer #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .ext_clk(ext_clk), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .flag_lo(flag_lo), .flag_hi(flag_hi), .irq(irq), .lo_wrap_stb(lo_wrap_stb)
  );

  // ---------------- reference model, from the requirements ----------------
  logic [5:0]   m_ctrl;
  logic [W-1:0] m_rld [2];
  logic [W-1:0] m_cnt [2];
  logic [1:0]   m_flag;
  logic         m_irq, m_stb;
  int           m_div, m_ecnt;
  logic [2:0]   m_sh;
  logic         t_div, t_ext, t_slow;
  logic [1:0]   t_tick, t_ld, t_wrap;

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = '0; m_flag = '0; m_irq = 0; m_stb = 0;
      m_div = 0; m_ecnt = 0; m_sh = '0;
      for (int i = 0; i < 2; i++) begin m_rld[i] = '0; m_cnt[i] = '0; end
    end else begin
      t_div  = (m_div == 11);
      t_ext  = (m_sh[1] && !m_sh[2]) && (m_ecnt == 7);
      t_slow = m_ctrl[1] ? t_ext : t_div;
      t_tick[0] = m_ctrl[3] | t_slow;
      t_tick[1] = m_ctrl[0] & (m_ctrl[2] | t_slow);
      t_ld[0] = wr_en && wr_addr == 3'd4;
      t_ld[1] = wr_en && wr_addr == 3'd5;
      m_irq = m_ctrl[4] & (m_flag[1] | (m_flag[0] & m_ctrl[5]));
      for (int i = 0; i < 2; i++) begin
        t_wrap[i] = t_tick[i] && !t_ld[i] && (m_cnt[i] == 8'hFF);
        if (t_ld[i])        m_cnt[i] = wr_data;
        else if (t_wrap[i]) m_cnt[i] = m_rld[i];
        else if (t_tick[i]) m_cnt[i] = m_cnt[i] + 8'd1;
      end
      m_stb = t_wrap[0];
      if (wr_en && wr_addr == 3'd1) m_flag = wr_data[1:0];
      else                          m_flag = m_flag | t_wrap;
      if (m_sh[1] && !m_sh[2]) m_ecnt = (m_ecnt == 7) ? 0 : m_ecnt + 1;
      m_div = t_div ? 0 : m_div + 1;
      m_sh  = {m_sh[1:0], ext_clk};
      if (wr_en && wr_addr == 3'd0) m_ctrl = wr_data[5:0];
      if (wr_en && wr_addr == 3'd2) m_rld[0] = wr_data;
      if (wr_en && wr_addr == 3'd3) m_rld[1] = wr_data;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // Lock-step comparison away from the active edge.
  always @(negedge clk) begin
    if (chk_on) begin
      check(cur_req, "cnt_lo", int'(cnt_lo), int'(m_cnt[0]));
      check(cur_req, "cnt_hi", int'(cnt_hi), int'(m_cnt[1]));
      check(cur_req, "flags", int'({flag_hi, flag_lo}), int'(m_flag));
      check(cur_req, "irq", int'(irq), int'(m_irq));
      check(cur_req, "strobe", int'(lo_wrap_stb), int'(m_stb));
    end
  end

  // External clock generator.
  always @(negedge clk) begin
    if (ext_run) begin
      ext_ph++;
      if (ext_ph >= ext_half) begin ext_ph = 0; ext_clk = ~ext_clk; end
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  int seed_dummy;

  initial begin
    seed_dummy = $urandom(32'd4711);
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    chk_on = 1'b1;
    // R1: reset state
    check("R1", "cnt_lo", int'(cnt_lo), 0);
    check("R1", "cnt_hi", int'(cnt_hi), 0);
    check("R1", "flags", int'({flag_hi, flag_lo}), 0);
    check("R1", "irq", int'(irq), 0);
    check("R1", "strobe", int'(lo_wrap_stb), 0);

    // R2: writes land one cycle later; ext select with idle ext_clk = no counting
    cur_req = "R2";
    wr(3'd0, 8'h02);
    wr(3'd4, 8'h37);
    check("R2", "cnt_lo after write", int'(cnt_lo), 'h37);
    wr(3'd5, 8'hC3);
    check("R2", "cnt_hi after write", int'(cnt_hi), 'hC3);
    wr(3'd5, 8'h00);

    // R4 and R8: wrap on system clock reloads and strobes once
    cur_req = "R4";
    wr(3'd2, 8'h40);
    wr(3'd4, 8'hFF);
    wr(3'd0, 8'h0A);
    @(negedge clk);
    check("R4", "cnt_lo reloaded", int'(cnt_lo), 'h40);
    check("R6", "flag_lo set on wrap", int'(flag_lo), 1);
    check("R8", "strobe after wrap", int'(lo_wrap_stb), 1);
    @(negedge clk);
    check("R8", "strobe single cycle", int'(lo_wrap_stb), 0);
    check("R4", "cnt_lo counts on", int'(cnt_lo), 'h41);

    // R9 and R6: counter write beats tick; flag write beats wrap
    cur_req = "R9";
    wr(3'd4, 8'hFF);
    check("R9", "cnt_lo write wins over tick", int'(cnt_lo), 'hFF);
    wr(3'd1, 8'h00);
    check("R6", "flag write beats wrap", int'(flag_lo), 0);
    check("R4", "cnt_lo reloaded under flag write", int'(cnt_lo), 'h40);
    idle(20);
    cur_req = "R6";
    idle(300);

    // R3: high half stopped, then running
    cur_req = "R3";
    wr(3'd0, 8'h06);
    idle(10);
    check("R3", "cnt_hi held while stopped", int'(cnt_hi), 0);
    wr(3'd0, 8'h07);
    idle(5);
    check("R3", "cnt_hi runs", int'(cnt_hi), 5);
    idle(300);
    check("R3", "flag_hi after wraps", int'(flag_hi), 1);

    // R7: interrupt combinations (counting frozen: ext select, ext idle)
    cur_req = "R7";
    wr(3'd0, 8'h02);
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h12);
    @(negedge clk);
    check("R7", "irq low flag without low enable", int'(irq), 0);
    wr(3'd0, 8'h32);
    @(negedge clk);
    check("R7", "irq low flag with low enable", int'(irq), 1);
    wr(3'd1, 8'h00);
    @(negedge clk);
    check("R7", "irq cleared with flags", int'(irq), 0);
    wr(3'd0, 8'h12);
    wr(3'd1, 8'h02);
    @(negedge clk);
    check("R7", "irq from high flag", int'(irq), 1);
    wr(3'd0, 8'h22);
    @(negedge clk);
    check("R7", "irq masked by global enable", int'(irq), 0);

    // R5: divide-by-12 and synchronized external rate
    cur_req = "R5";
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h01);
    idle(400);
    ext_run = 1'b1;
    ext_half = 2;
    wr(3'd0, 8'h03);
    idle(600);
    ext_half = 1;
    idle(300);

    // Random mix over all registers and rates
    cur_req = "R2";
    for (int n = 0; n < 6000; n++) begin
      if ($urandom_range(0, 99) == 0) ext_half = $urandom_range(1, 4);
      if ($urandom_range(0, 7) == 0) begin
        wr_en   = 1'b1;
        wr_addr = 3'($urandom_range(0, 5));
        wr_data = 8'($urandom);
        if (wr_addr == 3'd4 || wr_addr == 3'd5)
          if ($urandom_range(0, 1) == 1) wr_data = 8'hFE;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    idle(4);
    finish_run();
  end
endmodule